// File: doc/BRIEF.md
# Clock Synthesizer Serial Programming Sequencer

This block sits on the host side of a serially programmed clock synthesizer and writes one complete configuration into it. A parallel request supplies six fields: the reference divider word, the VCO divider word, the output divide select, the secondary output mode, the duty-threshold bit and the crystal load-capacitance code. The block first checks that the two divider words are legal. It then packs all six fields into a 24-bit frame and shifts the frame out MSB first on a serial clock and data pair. After the last bit it raises a commit strobe for one serial phase.

The synthesizer needs time to lock after a commit. For that reason `done` is held back until a programmable settle counter has run out. The serial clock comes from a programmable clock-enable divider, so each serial phase lasts `half_period+1` system cycles. The commit strobe stays low for the whole shift, so the synthesizer never latches a partial frame.

The controller has five states:
- `ST_IDLE`: waits for `req_valid`.
  - A legal request moves to `ST_SCLK_LO`.
  - An illegal request stays in `ST_IDLE` and pulses `error`.
- `ST_SCLK_LO`: the serial clock is low and the data bit is presented. A phase tick moves to `ST_SCLK_HI`.
- `ST_SCLK_HI`: the serial clock is high. On a phase tick the frame shifts.
  - After the 24th bit the tick moves to `ST_COMMIT`.
  - Otherwise it moves back to `ST_SCLK_LO`.
- `ST_COMMIT`: the strobe is high and the serial clock is low. A phase tick moves to `ST_SETTLE`.
- `ST_SETTLE`: the settle counter runs. When it expires the state returns to `ST_IDLE` and `done` pulses.

Top module: `synth_prog_seq`

## Requirements
- R1: A frame is 24 bits, sent first-to-last as: load code bit 1, load code bit 0, duty bit, mode bit 1, mode bit 0, divide select bits 2..0, VCO word bits 8..0, reference word bits 6..0. Each bit is captured on a rising edge of `ser_clk`.
- R2: `ser_strobe` stays low during all 24 shift cycles. It rises only after the 24th `ser_clk` rising edge, stays high for `half_period+1` cycles, and `ser_clk` is low throughout that time.
- R3: `ser_data` changes only while `ser_clk` is low. It is stable for every cycle that `ser_clk` is high.
- R4: Each high phase and each low phase of `ser_clk` lasts exactly `half_period+1` system cycles.
- R5: A request whose VCO word is below 4, or whose reference word is 0, is rejected. `error` is high for exactly the one cycle after the request, `busy` stays low, and `ser_clk` and `ser_strobe` do not toggle.
- R6: `busy` rises in the cycle after a legal request is accepted in idle. It stays high until the cycle in which `done` is asserted.
- R7: `ser_strobe` falls, then `settle_cycles+1` cycles later `done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R8: A request presented while `busy` is high is ignored. No extra frame and no error result from it.
- R9: During reset and right after it, all outputs are low.
- R10: Reference word 59, VCO word 276, divide select 1, duty bit 1, mode 2 and load code 0 produce the bits 00110001 10001010 00111011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_ref_div | input | 7 | Reference divider word |
| req_vco_div | input | 9 | VCO divider word |
| req_out_sel | input | 3 | Output divide select |
| req_aux_mode | input | 2 | Secondary output mode code |
| req_duty_sel | input | 1 | Duty-threshold bit |
| req_load_cap | input | 2 | Crystal load-capacitance code |
| half_period | input | HALF_W | Serial clock phase length minus one, in system cycles |
| settle_cycles | input | SETTLE_W | Lock wait length minus one, in system cycles |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_strobe | output | 1 | Commit strobe |
| busy | output | 1 | A frame is in progress or settling |
| done | output | 1 | One-cycle pulse when the settle time has ended |
| error | output | 1 | One-cycle pulse when a request is rejected |

## Verification
The assertions assume that `half_period` and `settle_cycles` are held constant while `busy` is high, and that `req_valid` is a single-cycle pulse. The stimulus changes both timing inputs only while the block is idle. It drives every request on the falling clock edge and drops it one cycle later. The only exceptions are deliberate requests sent during a busy frame, which exercise the rule that such requests are ignored.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int RDW_W   = 7;
    localparam int VDW_W   = 9;
    localparam int OD_W    = 3;
    localparam int MODE_W  = 2;
    localparam int CAP_W   = 2;
    localparam int FRAME_W = CAP_W + 1 + MODE_W + OD_W + VDW_W + RDW_W;
    localparam int BIT_CNT_W = $clog2(FRAME_W);
    localparam int VDW_MIN = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCLK_LO,
        ST_SCLK_HI,
        ST_COMMIT,
        ST_SETTLE
    } seq_state_e;

    // Field order from MSB to LSB is the transmit order.
    typedef struct packed {
        logic [CAP_W-1:0]  load_cap;
        logic              duty_sel;
        logic [MODE_W-1:0] aux_mode;
        logic [OD_W-1:0]   out_sel;
        logic [VDW_W-1:0]  vco_div;
        logic [RDW_W-1:0]  ref_div;
    } synth_cfg_t;

    function automatic logic cfg_legal(input synth_cfg_t c);
        return (c.vco_div >= VDW_W'(VDW_MIN)) && (c.ref_div != '0);
    endfunction

endpackage

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] half,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = en && (cnt_q == half);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    phase_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q <= half));

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    assign expired = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    settle_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));

endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
    import synth_prog_pkg::*;
#(
    parameter int HALF_W   = 8,
    parameter int SETTLE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [RDW_W-1:0]    req_ref_div,
    input  logic [VDW_W-1:0]    req_vco_div,
    input  logic [OD_W-1:0]     req_out_sel,
    input  logic [MODE_W-1:0]   req_aux_mode,
    input  logic                req_duty_sel,
    input  logic [CAP_W-1:0]    req_load_cap,
    input  logic [HALF_W-1:0]   half_period,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                ser_clk,
    output logic                ser_data,
    output logic                ser_strobe,
    output logic                busy,
    output logic                done,
    output logic                error
);
    seq_state_e             state_q, state_d;
    synth_cfg_t             req_cfg;
    logic [FRAME_W-1:0]     shift_q;
    logic [BIT_CNT_W-1:0]   bit_cnt_q;
    logic                   done_q, err_q;
    logic                   phase_tick, settle_done;
    logic                   req_ok, last_bit;

    assign req_cfg = '{load_cap: req_load_cap, duty_sel: req_duty_sel,
                       aux_mode: req_aux_mode, out_sel: req_out_sel,
                       vco_div: req_vco_div, ref_div: req_ref_div};
    assign req_ok   = cfg_legal(req_cfg);
    assign last_bit = (bit_cnt_q == BIT_CNT_W'(FRAME_W - 1));

    sclk_phase_gen #(.W(HALF_W)) phase_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    ((state_q == ST_SCLK_LO) || (state_q == ST_SCLK_HI) || (state_q == ST_COMMIT)),
        .half  (half_period),
        .tick  (phase_tick)
    );

    settle_timer #(.W(SETTLE_W)) settle_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_SETTLE),
        .limit   (settle_cycles),
        .expired (settle_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid && req_ok) state_d = ST_SCLK_LO;
            ST_SCLK_LO: if (phase_tick) state_d = ST_SCLK_HI;
            ST_SCLK_HI: if (phase_tick) state_d = last_bit ? ST_COMMIT : ST_SCLK_LO;
            ST_COMMIT:  if (phase_tick) state_d = ST_SETTLE;
            ST_SETTLE:  if (settle_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Frame shifter, bit counter and result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bit_cnt_q <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= (state_q == ST_SETTLE) && settle_done;
            err_q  <= (state_q == ST_IDLE) && req_valid && !req_ok;
            if (state_q == ST_IDLE && req_valid && req_ok) begin
                shift_q   <= req_cfg;
                bit_cnt_q <= '0;
            end else if (state_q == ST_SCLK_HI && phase_tick) begin
                shift_q   <= {shift_q[FRAME_W-2:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        ser_clk    = 1'b0;
        ser_data   = 1'b0;
        ser_strobe = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_SCLK_LO: ser_data = shift_q[FRAME_W-1];
            ST_SCLK_HI: begin
                ser_clk  = 1'b1;
                ser_data = shift_q[FRAME_W-1];
            end
            ST_COMMIT:  ser_strobe = 1'b1;
            ST_SETTLE:  ;
            default:    busy = 1'b0;
        endcase
        done  = done_q;
        error = err_q;
    end

    // R2
    strobe_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_strobe |-> !ser_clk);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R5
    error_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!busy && $past(!busy)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($fell(busy) && !ser_strobe));

endmodule

// File: tb/synth_prog_seq_tb_top.sv
module synth_prog_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_W = 8;
    localparam int SETTLE_W = 20;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [6:0] req_ref_div = '0;
    logic [8:0] req_vco_div = '0;
    logic [2:0] req_out_sel = '0;
    logic [1:0] req_aux_mode = '0;
    logic req_duty_sel = 1'b0;
    logic [1:0] req_load_cap = '0;
    logic [HALF_W-1:0] half_period = '0;
    logic [SETTLE_W-1:0] settle_cycles = '0;
    logic ser_clk, ser_data, ser_strobe, busy, done, error;

    int checks = 0;
    int failures = 0;
    int frames_seen = 0;
    int frames_sent = 0;
    logic [23:0] exp_q[$];
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_prog_seq #(.HALF_W(HALF_W), .SETTLE_W(SETTLE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_ref_div(req_ref_div), .req_vco_div(req_vco_div),
        .req_out_sel(req_out_sel), .req_aux_mode(req_aux_mode),
        .req_duty_sel(req_duty_sel), .req_load_cap(req_load_cap),
        .half_period(half_period), .settle_cycles(settle_cycles),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe),
        .busy(busy), .done(done), .error(error)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: reassembles frames and pops the scoreboard on each strobe
    logic prev_clk = 1'b0, prev_data = 1'b0, prev_strobe = 1'b0;
    logic [23:0] rx_bits = '0;
    int rx_cnt = 0;
    int hi_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk && !prev_clk) begin
                rx_bits = {rx_bits[22:0], ser_data};
                rx_cnt++;
                chk(!ser_strobe, "R2 strobe during shift", 32'(ser_strobe), 0);
            end
            if (ser_clk && prev_clk)
                chk(ser_data == prev_data, "R3 data moved while clk high", 32'(ser_data), 32'(prev_data));
            if (ser_clk) hi_len++;
            if (!ser_clk && prev_clk) begin
                chk(hi_len == int'(half_period) + 1, "R4 high phase length", 32'(hi_len), 32'(half_period) + 1);
                hi_len = 0;
            end
            if (ser_strobe && !prev_strobe) begin
                chk(rx_cnt == 24, "R2 bits before strobe", 32'(rx_cnt), 24);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected frame", 32'(rx_bits), 0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk(rx_bits == e, "R1 frame content", 32'(rx_bits), 32'(e));
                end
                frames_seen++;
                rx_cnt = 0;
            end
            if (ser_strobe)
                chk(!ser_clk, "R2 clk low during strobe", 32'(ser_clk), 0);
        end
        prev_clk = ser_clk;
        prev_data = ser_data;
        prev_strobe = ser_strobe;
    end

    // Driver: one request; legal ones push the expected frame
    task automatic send(input logic [6:0] r, input logic [8:0] v, input logic [2:0] o,
                        input logic [1:0] m, input logic d, input logic [1:0] c);
        bit legal;
        legal = (v >= 9'd4) && (r != 7'd0);
        @(negedge clk);
        req_ref_div = r; req_vco_div = v; req_out_sel = o;
        req_aux_mode = m; req_duty_sel = d; req_load_cap = c;
        req_valid = 1'b1;
        if (legal) begin
            exp_q.push_back({c, d, m, o, v, r});
            frames_sent++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (legal) begin
            chk(busy == 1'b1, "R6 busy after accept", 32'(busy), 1);
            chk(error == 1'b0, "R5 no error on legal", 32'(error), 0);
        end else begin
            chk(error == 1'b1, "R5 error pulse", 32'(error), 1);
            chk(busy == 1'b0, "R5 busy stays low", 32'(busy), 0);
            @(negedge clk);
            chk(error == 1'b0, "R5 error one cycle", 32'(error), 0);
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (ser_clk || ser_strobe || busy)
                    chk(1'b0, "R5 activity after reject", {29'd0, ser_clk, ser_strobe, busy}, 0);
            end
            chk(!ser_clk && !ser_strobe && !busy, "R5 quiet after reject", {29'd0, ser_clk, ser_strobe, busy}, 0);
        end
    endtask

    task automatic intrude();
        for (int i = 0; i < 7; i++) @(negedge clk);
        chk(busy == 1'b1, "R8 intrusion while busy", 32'(busy), 1);
        req_ref_div = 7'd0; req_vco_div = 9'd1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(error == 1'b0, "R8 no error while busy", 32'(error), 0);
        req_ref_div = 7'd33; req_vco_div = 9'd300; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!ser_strobe && n < 5000) begin @(negedge clk); n++; end
        while (ser_strobe && n < 5000) begin @(negedge clk); n++; end
        n = 0;
        while (!done && n < 5000) begin
            if (!busy) chk(1'b0, "R6 busy dropped early", 32'(busy), 1);
            @(negedge clk);
            n++;
        end
        chk(n == int'(settle_cycles) + 1, "R7 settle length", 32'(n), 32'(settle_cycles) + 1);
        chk(busy == 1'b0, "R7 busy low at done", 32'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single pulse", 32'(done), 0);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: outputs low during reset
        chk({ser_clk, ser_data, ser_strobe, busy, done, error} == 6'd0, "R9 in reset",
            {26'd0, ser_clk, ser_data, ser_strobe, busy, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ser_clk, ser_data, ser_strobe, busy, done, error} == 6'd0, "R9 after reset",
            {26'd0, ser_clk, ser_data, ser_strobe, busy, done, error}, 0);

        // R10: known frame, checked against literal bytes
        half_period = 8'd1; settle_cycles = 20'd10;
        send(7'd59, 9'd276, 3'd1, 2'd2, 1'b1, 2'd0);
        chk(exp_q[0] == 24'b00110001_10001010_00111011, "R10 expected bytes", 32'(exp_q[0]), 32'h318A3B);
        wait_done();

        // R1 boundary legal values, fastest timing
        half_period = 8'd0; settle_cycles = 20'd0;
        send(7'd1, 9'd4, 3'd7, 2'd3, 1'b0, 2'd3);
        wait_done();

        // R8 requests during busy are ignored
        half_period = 8'd3; settle_cycles = 20'd25;
        send(7'd127, 9'd511, 3'd0, 2'd1, 1'b0, 2'd2);
        intrude();
        wait_done();

        // R1 alternating pattern
        half_period = 8'd2; settle_cycles = 20'd5;
        send(7'h55, 9'h0AA, 3'd5, 2'd0, 1'b1, 2'd1);
        wait_done();

        // R5 illegal words
        send(7'd0, 9'd100, 3'd2, 2'd1, 1'b0, 2'd0);
        send(7'd20, 9'd3, 3'd2, 2'd1, 1'b0, 2'd0);
        send(7'd0, 9'd0, 3'd0, 2'd0, 1'b0, 2'd0);

        repeat (10) @(negedge clk);
        chk(frames_seen == frames_sent, "R8 frame count", 32'(frames_seen), 32'(frames_sent));
        chk(exp_q.size() == 0, "R1 scoreboard drained", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule